// File: doc/BRIEF.md
# Multi-Channel Compare System Timer

A memory-mapped timer peripheral built around a free-running up-counter that advances once per programmable number of clock cycles. Several compare channels watch the counter; each one owns an enable bit, a compare value and a sticky match flag. One interrupt line reports any channel whose flag is set while it is enabled.

Software reaches everything through a plain word-addressed bus: address, write strobe, write data and combinational read data. The counter can be loaded by software at any time. The counter and its divider can be made to stop while a debug-halt input is high. After reset the timer is stopped, every register is zero and no channel is enabled.

Top module: `sys_cmp_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The control word at byte offset 0x00 holds run-enable in bit 0, freeze-on-halt in bit 1 and the prescale value P in bits 15:8. It reads back what was written, and its other bits read zero.
- R2: While run-enable is set, the counter steps by one once every P+1 clocks. The first step lands on the (P+1)-th rising edge after the edge that set run-enable.
- R3: The count word at byte offset 0x04 reads the counter. A write loads the written value, and that load wins over a step due in the same cycle.
- R4: The counter counts up only and wraps from 0xFFFFFFFF to 0.
- R5: Clearing run-enable holds the counter and zeroes the divider, so the next enable waits a full P+1 period before the first step.
- R6: With freeze-on-halt set and `dbg_halt` high, the counter and the divider hold. With freeze-on-halt clear, `dbg_halt` has no effect.
- R7: Channel n (0..3) has a control word at 0x10+0x10·n (enable in bit 0), a flag word at 0x14+0x10·n (match flag in bit 0) and a 32-bit compare word at 0x18+0x10·n.
- R8: A channel's flag becomes 1 on the clock edge where the channel is enabled and the counter takes (or keeps) a value equal to the compare word. A disabled channel never sets its flag.
- R9: A flag stays set until a write of 1 to bit 0 of its flag word. Writing 0 there has no effect. If a set condition and a clear happen in the same cycle, the flag stays set.
- R10: `irq` is high exactly when some channel has both its enable and its flag set. Disabling a channel masks its flag from `irq` but keeps the flag.
- R11: Reserved bits read zero. Unmapped or unaligned offsets (0x08, 0x0C, 0x1C, 0x50 and above, any address with bits 1:0 non-zero) read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dbg_halt | input | 1 | Debug-halt request |
| irq | output | 1 | Combined pending-match interrupt |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as a live match. Because the counter steps through values, a plain write of 1 to the flag word rarely coincides with equality. The stimulus first stops the timer, then loads the counter with the compare value so that the match holds on every cycle, and only then issues the clear. This shows that the set wins. A second case is the divider reset on disable. The timer is stopped part-way through a prescale period and restarted, and the stimulus then counts the edges to the first step to show that a full period elapses.

// File: rtl/sct_pkg.sv
package sct_pkg;

    // Global register offsets (bytes)
    localparam int unsigned OFS_CTRL     = 0;
    localparam int unsigned OFS_COUNT    = 4;

    // Control word bit positions
    localparam int unsigned CTL_RUN_BIT  = 0;
    localparam int unsigned CTL_FRZ_BIT  = 1;
    localparam int unsigned CTL_PSC_LSB  = 8;

    // Word slot inside a 16-byte channel group
    typedef enum logic [1:0] {
        SUB_CTL  = 2'd0,
        SUB_FLG  = 2'd1,
        SUB_CMP  = 2'd2,
        SUB_NONE = 2'd3
    } ch_sub_e;

endpackage

// File: rtl/sct_prescaler.sv
module sct_prescaler #(
    parameter int unsigned PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             halt,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.div = '0;
        end else if (!halt) begin
            // >= keeps the divider sane when P is lowered mid-period
            if (st_q.div >= psc) begin
                tick     = 1'b1;
                st_d.div = '0;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sct_counter.sv
module sct_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign cnt     = st_q.cnt;
    assign cnt_nxt = st_d.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sct_channel.sv
module sct_channel #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_flg,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             en,
    output logic             flag,
    output logic [CNT_W-1:0] cmp,
    output logic             pend
);

    typedef struct packed {
        logic             en;
        logic             flag;
        logic [CNT_W-1:0] cmp;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.en && (cnt_nxt == st_q.cmp);
        if (wr_ctl) st_d.en  = wdata[0];
        if (wr_cmp) st_d.cmp = wdata;
        if (wr_flg && wdata[0]) st_d.flag = 1'b0;
        // a live match outranks a clear in the same cycle
        if (hit) st_d.flag = 1'b1;
    end

    assign en   = st_q.en;
    assign flag = st_q.flag;
    assign cmp  = st_q.cmp;
    assign pend = st_q.en & st_q.flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sys_cmp_timer.sv
module sys_cmp_timer #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned PSC_W  = 8,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_halt,
    output logic              irq
);
    import sct_pkg::*;

    localparam int unsigned RGN_W = ADDR_W - 4;

    typedef struct packed {
        logic             run;
        logic             frz;
        logic [PSC_W-1:0] psc;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    // ---------------- address decode ----------------
    logic [RGN_W-1:0] rgn;
    ch_sub_e          sub;
    logic             aligned;
    logic             hit_ctrl;
    logic             hit_cnt;
    logic [NUM_CH-1:0] hit_ch;

    assign rgn      = bus_addr[ADDR_W-1:4];
    assign sub      = ch_sub_e'(bus_addr[3:2]);
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign hit_ctrl = aligned && (rgn == '0) && ({bus_addr[3:2], 2'b00} == 4'(OFS_CTRL));
    assign hit_cnt  = aligned && (rgn == '0) && ({bus_addr[3:2], 2'b00} == 4'(OFS_COUNT));

    // ---------------- control word ----------------
    always_comb begin
        ctl_d = ctl_q;
        if (bus_we && hit_ctrl) begin
            ctl_d.run = bus_wdata[CTL_RUN_BIT];
            ctl_d.frz = bus_wdata[CTL_FRZ_BIT];
            ctl_d.psc = bus_wdata[CTL_PSC_LSB +: PSC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic run_q;
    logic frz_q;
    assign run_q = ctl_q.run;
    assign frz_q = ctl_q.frz;

    // ---------------- prescaler and counter ----------------
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    sct_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .halt  (frz_q & dbg_halt),
        .psc   (ctl_q.psc),
        .tick  (tick)
    );

    sct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (bus_we && hit_cnt),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt_q),
        .cnt_nxt  (cnt_nxt)
    );

    // ---------------- compare channels ----------------
    logic [NUM_CH-1:0] ch_en_v;
    logic [NUM_CH-1:0] ch_flag_v;
    logic [NUM_CH-1:0] ch_pend_v;
    logic [CNT_W-1:0]  ch_cmp [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign hit_ch[g] = aligned && (rgn == RGN_W'(g + 1));

        sct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (bus_we && hit_ch[g] && (sub == SUB_CTL)),
            .wr_flg  (bus_we && hit_ch[g] && (sub == SUB_FLG)),
            .wr_cmp  (bus_we && hit_ch[g] && (sub == SUB_CMP)),
            .wdata   (bus_wdata[CNT_W-1:0]),
            .cnt_nxt (cnt_nxt),
            .en      (ch_en_v[g]),
            .flag    (ch_flag_v[g]),
            .cmp     (ch_cmp[g]),
            .pend    (ch_pend_v[g])
        );
    end

    assign irq = |ch_pend_v;

    // ---------------- read-back ----------------
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[CTL_RUN_BIT]              = ctl_q.run;
            bus_rdata[CTL_FRZ_BIT]              = ctl_q.frz;
            bus_rdata[CTL_PSC_LSB +: PSC_W]     = ctl_q.psc;
        end
        if (hit_cnt) begin
            bus_rdata[CNT_W-1:0] = cnt_q;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_ch[i]) begin
                case (sub)
                    SUB_CTL: bus_rdata[0]         = ch_en_v[i];
                    SUB_FLG: bus_rdata[0]         = ch_flag_v[i];
                    SUB_CMP: bus_rdata[CNT_W-1:0] = ch_cmp[i];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              dbg_halt,
    input logic              irq,
    input logic              run,
    input logic              frz,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_flag
);

    logic wr_cnt;
    assign wr_cnt = bus_we && (bus_addr == ADDR_W'(4));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_no_tick_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));

    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frz && dbg_halt && !wr_cnt) |=> $stable(cnt));

    assert_no_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> !irq);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic clr_wr;
        assign clr_wr = bus_we && bus_wdata[0] &&
                        (bus_addr == ADDR_W'(16 * (g + 1) + 4));

        assert_set_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_flag[g]) |-> $past(ch_en[g]));

        assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_flag[g] && !clr_wr) |=> ch_flag[g]);
    end

endmodule

bind sys_cmp_timer sct_checker #(
    .CNT_W  (CNT_W),
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_sct_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dbg_halt  (dbg_halt),
    .irq       (irq),
    .run       (run_q),
    .frz       (frz_q),
    .tick      (tick),
    .cnt       (cnt_q),
    .ch_en     (ch_en_v),
    .ch_flag   (ch_flag_v)
);

// File: tb/sys_cmp_timer_bench.sv
module sys_cmp_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    sys_cmp_timer u_sys_cmp_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dbg_halt  (dbg_halt),
        .irq       (irq)
    );

    // scoreboard queues: expected value, message, kind (1 = irq pin)
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          kind_q[$];

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [31:0] m_exp;
    logic [31:0] m_act;
    string       m_tag;
    bit          m_kind;

    // monitor: compares one cycle's expectations 1 ns after the falling edge
    initial begin : monitor
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                m_exp  = exp_q.pop_front();
                m_tag  = tag_q.pop_front();
                m_kind = kind_q.pop_front();
                m_act  = m_kind ? {31'b0, irq} : bus_rdata;
                n_chk++;
                if (m_act !== m_exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", m_tag, m_act, m_exp);
                end
            end
        end
    end

    // every task starts at a falling edge and consumes exactly one rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        bus_addr = a;
        bus_we   = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(t);
        kind_q.push_back(1'b0);
        #2;
        @(negedge clk);
    endtask

    task automatic ck_irq(input logic e, input string t);
        exp_q.push_back({31'b0, e});
        tag_q.push_back(t);
        kind_q.push_back(1'b1);
        #2;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and control layout
        rd(8'h00, 32'h0, "R1 ctrl after reset");
        rd(8'h04, 32'h0, "R1 count after reset");
        rd(8'h18, 32'h0, "R1 cmp0 after reset");
        ck_irq(1'b0, "R1 irq after reset");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_FF03, "R1 ctrl fields and reserved bits");
        wr(8'h00, 32'h0);

        // R2 prescale period P=3: first step on 4th edge after enable
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0000_0301);
        rd(8'h04, 32'd0, "R2 P=3 edge1");
        rd(8'h04, 32'd0, "R2 P=3 edge2");
        rd(8'h04, 32'd0, "R2 P=3 edge3");
        rd(8'h04, 32'd0, "R2 P=3 edge4");
        rd(8'h04, 32'd1, "R2 P=3 first step");
        idle(3);
        rd(8'h04, 32'd2, "R2 P=3 second step");

        // R3 load beats a coincident step, R4 wrap
        wr(8'h00, 32'h0000_0001);
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, 32'h1234_5678, "R3 load wins over step");
        rd(8'h04, 32'h1234_5679, "R2 P=0 steps each clock");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'hFFFF_FFFF, "R4 at top");
        rd(8'h04, 32'h0000_0000, "R4 wrap to zero");

        // R5 hold when stopped, divider restarts
        wr(8'h04, 32'd100);
        wr(8'h00, 32'h0);
        rd(8'h04, 32'd101, "R5 hold after stop a");
        rd(8'h04, 32'd101, "R5 hold after stop b");
        wr(8'h04, 32'd500);
        wr(8'h00, 32'h0000_0301);
        idle(2);
        wr(8'h00, 32'h0000_0300);
        wr(8'h00, 32'h0000_0301);
        rd(8'h04, 32'd500, "R5 restart edge1");
        rd(8'h04, 32'd500, "R5 restart edge2");
        rd(8'h04, 32'd500, "R5 restart edge3");
        rd(8'h04, 32'd500, "R5 restart edge4");
        rd(8'h04, 32'd501, "R5 full period after restart");

        // R6 freeze on debug halt
        wr(8'h00, 32'h0000_0001);
        dbg_halt = 1'b1;
        wr(8'h00, 32'h0000_0003);
        wr(8'h04, 32'd1000);
        rd(8'h04, 32'd1000, "R6 frozen a");
        rd(8'h04, 32'd1000, "R6 frozen b");
        dbg_halt = 1'b0;
        rd(8'h04, 32'd1000, "R6 release");
        rd(8'h04, 32'd1001, "R6 resumes");
        wr(8'h00, 32'h0000_0001);
        dbg_halt = 1'b1;
        wr(8'h04, 32'd2000);
        rd(8'h04, 32'd2000, "R6 halt ignored a");
        rd(8'h04, 32'd2001, "R6 halt ignored b");
        dbg_halt = 1'b0;

        // R7..R10 channel 0 with timer stopped
        wr(8'h00, 32'h0);
        wr(8'h04, 32'd50);
        wr(8'h18, 32'd52);
        wr(8'h10, 32'h1);
        rd(8'h18, 32'd52, "R7 cmp0 readback");
        rd(8'h14, 32'h0, "R8 no match yet");
        ck_irq(1'b0, "R10 irq low before match");
        wr(8'h04, 32'd52);
        rd(8'h14, 32'h1, "R8 flag on match");
        ck_irq(1'b1, "R10 irq on pending match");
        wr(8'h04, 32'd60);
        rd(8'h14, 32'h1, "R9 sticky after counter moves");
        wr(8'h14, 32'h0);
        rd(8'h14, 32'h1, "R9 write zero no effect");
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h0, "R9 write one clears");
        ck_irq(1'b0, "R10 irq low after clear");
        wr(8'h04, 32'd52);
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h1, "R9 live match beats clear");
        wr(8'h04, 32'd53);
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h0, "R9 clear without match");

        // R8 disabled channel, R10 masking, channel 1
        wr(8'h28, 32'd53);
        idle(2);
        rd(8'h24, 32'h0, "R8 disabled channel no set");
        wr(8'h20, 32'h1);
        idle(1);
        rd(8'h24, 32'h1, "R8 set once enabled");
        ck_irq(1'b1, "R10 irq from ch1");
        wr(8'h20, 32'h0);
        ck_irq(1'b0, "R10 disabled channel masked");
        rd(8'h24, 32'h1, "R10 flag kept while masked");
        rd(8'h20, 32'h0, "R7 ch1 ctl readback");
        wr(8'h24, 32'h1);
        rd(8'h24, 32'h0, "R9 ch1 cleared");

        // R7 channel 3 group, match while counting
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, 32'h1, "R11 ch3 ctl reserved bits");
        wr(8'h48, 32'd1003);
        rd(8'h48, 32'd1003, "R7 cmp3 readback");
        wr(8'h04, 32'd1000);
        rd(8'h44, 32'h0, "R8 ch3 before match");
        wr(8'h00, 32'h0000_0001);
        idle(5);
        rd(8'h44, 32'h1, "R8 ch3 match while counting");
        ck_irq(1'b1, "R10 irq from ch3");
        wr(8'h00, 32'h0);
        wr(8'h40, 32'h0);
        wr(8'h44, 32'h1);
        ck_irq(1'b0, "R10 irq low all clear");
        rd(8'h34, 32'h0, "R7 ch2 flag untouched");

        // R11 unmapped and unaligned
        rd(8'h08, 32'h0, "R11 offset 08 reads zero");
        rd(8'h1C, 32'h0, "R11 offset 1C reads zero");
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, 32'h0, "R11 offset 50 reads zero");
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R11 ctrl untouched by stray writes");
        rd(8'h01, 32'h0, "R11 unaligned reads zero");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule